// File: doc/BRIEF.md
# Trigger Tower Formatter

This block turns one bunch crossing's worth of calorimeter samples into a trigger primitive frame. Two trigger towers are handled, and each is fed by a front-depth and a back-depth channel. Every channel delivers a compressed 8-bit energy code and a 2-bit error field. Each code addresses a private 256-entry table that holds 16-bit linear transverse energy. The two depths of a tower are added with one spare bit, so the full range of the sum is kept. The sum is tested against a programmable inclusive window that flags minimum-ionizing muon candidates. It is then cut to 8 bits with saturation.

Each crossing produces one 24-bit frame. The frame holds both truncated tower energies, both muon flags and the abort-gap marker, all protected by five single-error-correcting Hamming check bits. The datapath is fully pipelined. It takes a new sample set every clock and delivers the frame a fixed three cycles later, with a valid strobe that travels with the data. Table contents are written one entry per clock through a plain write port.

Top module: `trig_tower_formatter`

## Requirements
- R1: Channel index c (0 = tower A front, 1 = tower A back, 2 = tower B front, 3 = tower B back) looks up its own 256 x 16 table at address smp_code[c]. A table write on a clock edge is seen by samples captured on later edges. A sample captured on the same edge reads the old entry.
- R2: The tower energy is the 17-bit sum of the front and back table outputs. When no error is present and the sum is at most 255, the ET field equals the sum.
- R3: A sum above 255, including a sum that needs the 17th bit, gives an ET field of 0xFF.
- R4: Any nonzero error bit on either channel of a tower forces that tower's ET field to 0xFF and its muon flag to 0.
- R5: When no error is present, a tower's muon flag is 1 exactly when mu_lo <= sum <= mu_hi. The comparison uses the full 17-bit sum.
- R6: Frame positions are numbered 1 to 24, and position p is frm_data bit p-1. The check bits occupy positions 1, 2, 4, 8 and 16. The payload fills the other positions in ascending order, in this sequence: tower A ET bits 0 to 7, tower A muon flag, tower B ET bits 0 to 7, tower B muon flag, abort flag.
- R7: Check bit k (at position 2^k) makes the XOR of every frame position whose index has bit k set equal to zero.
- R8: frm_valid is high exactly three clocks after smp_valid was sampled high. Back-to-back samples give back-to-back frames with no stall.
- R9: During reset, frm_valid and frm_data are 0.
- R10: The abort_gap input sampled with a crossing appears as that crossing's abort flag in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample set present this cycle |
| smp_code | input | 4x8 | Compressed energy code per channel |
| smp_err | input | 4x2 | Error bits per channel |
| abort_gap | input | 1 | Crossing lies in the abort gap |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_ch | input | 2 | Channel whose table is written |
| tbl_wr_addr | input | 8 | Table entry written |
| tbl_wr_data | input | 16 | Linear energy written |
| mu_lo | input | 16 | Lower inclusive muon window bound |
| mu_hi | input | 16 | Upper inclusive muon window bound |
| frm_valid | output | 1 | Frame present |
| frm_data | output | 24 | Protected trigger frame |

## Verification
The bench drives sums that land exactly on both window bounds and one unit outside each. A design with an exclusive or off-by-one compare would flip the muon flag in those cycles. It also drives sums of exactly 255 and 256, and a 17-bit sum from two full-scale entries. A design that wraps instead of saturating, or compares only 16 bits against the window, would show a small ET or a stray muon flag. A table entry is rewritten on the same edge that a sample reads it, which exposes write-first forwarding. Error bits are injected while the energy sits inside the window, so a design that fails to suppress the flag is caught. Long random runs with back-to-back samples check the three-cycle latency and every check bit of the frame.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
   localparam int unsigned NUM_TOW     = 2;
   localparam int unsigned DEP_PER_TOW = 2;
   localparam int unsigned NUM_CH      = NUM_TOW * DEP_PER_TOW;

   // smallest number of check bits able to cover dw payload bits
   function automatic int unsigned chk_count(input int unsigned dw);
      int unsigned p;
      p = 0;
      while ((32'd1 << p) < dw + p + 1) p = p + 1;
      return p;
   endfunction

   function automatic bit is_pow2(input int unsigned x);
      return (x != 0) && ((x & (x - 1)) == 0);
   endfunction
endpackage

// File: rtl/tpf_lut.sv
module tpf_lut #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   if (ADDR_W > 12) begin : g_bad_addr
      $error("tpf_lut: ADDR_W too large");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   // read returns the entry held before a same-edge write
   always_ff @(posedge clk) begin
      rd_data <= mem[rd_addr];
      if (wr_en) mem[wr_addr] <= wr_data;
   end
endmodule

// File: rtl/tpf_tower.sv
module tpf_tower #(
   parameter int unsigned ET_W  = 16,
   parameter int unsigned OUT_W = 8,
   parameter int unsigned ERR_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [ET_W-1:0]  et_f,
   input  logic [ET_W-1:0]  et_b,
   input  logic [ERR_W-1:0] err_f,
   input  logic [ERR_W-1:0] err_b,
   input  logic [ET_W-1:0]  mu_lo,
   input  logic [ET_W-1:0]  mu_hi,
   output logic [OUT_W-1:0] et_o,
   output logic             mu_o
);
   localparam int unsigned SUM_W = ET_W + 1;

   if (OUT_W >= ET_W) begin : g_bad_width
      $error("tpf_tower: OUT_W must be below ET_W");
   end

   logic [SUM_W-1:0] sum;
   logic             bad;
   logic             in_win;
   logic             ovr;

   always_comb begin
      sum    = {1'b0, et_f} + {1'b0, et_b};
      bad    = |{err_f, err_b};
      in_win = (sum >= {1'b0, mu_lo}) && (sum <= {1'b0, mu_hi});
      ovr    = |sum[SUM_W-1:OUT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         et_o <= '0;
         mu_o <= 1'b0;
      end else if (in_vld) begin
         if (bad) begin
            et_o <= '1;
            mu_o <= 1'b0;
         end else begin
            et_o <= ovr ? '1 : sum[OUT_W-1:0];
            mu_o <= in_win;
         end
      end
   end

   // R4: an error on either depth marks the tower
   a_r4_err_marks: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && (|err_f || |err_b) |=> (et_o == '1) && !mu_o);

   // R3: oversize sums clamp to full scale
   a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && !bad && (sum > SUM_W'((1 << OUT_W) - 1)) |=> et_o == '1);

   // R2: small sums pass through unchanged
   a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && !bad && !ovr |=> et_o == $past(sum[OUT_W-1:0]));

   // R5: inside the window sets the flag, outside clears it
   a_r5_window_hit: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && !bad && in_win |=> mu_o);
   a_r5_window_miss: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && !in_win |=> !mu_o);
endmodule

// File: rtl/tpf_frame_pack.sv
module tpf_frame_pack
   import tpf_pkg::*;
#(
   parameter int unsigned OUT_W = 8,
   localparam int unsigned DW = 2 * (OUT_W + 1) + 1,
   localparam int unsigned PW = chk_count(DW),
   localparam int unsigned FW = DW + PW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [OUT_W-1:0] et_a,
   input  logic             mu_a,
   input  logic [OUT_W-1:0] et_b,
   input  logic             mu_b,
   input  logic             abort,
   output logic             frm_vld,
   output logic [FW-1:0]    frm
);
   if (FW > 32) begin : g_bad_frame
      $error("tpf_frame_pack: frame wider than 32 bits");
   end

   logic [DW-1:0] pay;
   logic [FW-1:0] word;

   always_comb begin
      int di;
      pay  = {abort, mu_b, et_b, mu_a, et_a};
      word = '0;
      di   = 0;
      for (int p = 1; p <= int'(FW); p++) begin
         if (!is_pow2(p)) begin
            word[p-1] = pay[di];
            di++;
         end
      end
      for (int k = 0; k < int'(PW); k++) begin
         logic par;
         par = 1'b0;
         for (int p = 1; p <= int'(FW); p++) begin
            if (((p >> k) & 1) == 1) par = par ^ word[p-1];
         end
         word[(1 << k) - 1] = par;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_vld <= 1'b0;
         frm     <= '0;
      end else begin
         frm_vld <= in_vld;
         if (in_vld) frm <= word;
      end
   end

   logic [PW-1:0] syn;
   always_comb begin
      for (int k = 0; k < int'(PW); k++) begin
         syn[k] = 1'b0;
         for (int p = 1; p <= int'(FW); p++) begin
            if (((p >> k) & 1) == 1) syn[k] = syn[k] ^ frm[p-1];
         end
      end
   end

   // R7: every emitted frame decodes with a clean syndrome
   a_r7_syndrome_clear: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |-> syn == '0);

   // R10: abort marker lands in the last payload position
   a_r10_abort_kept: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> frm[FW-1] == $past(abort));
endmodule

// File: rtl/trig_tower_formatter.sv
module trig_tower_formatter
   import tpf_pkg::*;
#(
   parameter int unsigned CODE_W = 8,
   parameter int unsigned ET_W   = 16,
   parameter int unsigned OUT_W  = 8,
   parameter int unsigned ERR_W  = 2,
   localparam int unsigned CH_W  = $clog2(NUM_CH),
   localparam int unsigned DW    = 2 * (OUT_W + 1) + 1,
   localparam int unsigned FRM_W = DW + chk_count(DW)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               smp_valid,
   input  logic [NUM_CH-1:0][CODE_W-1:0]      smp_code,
   input  logic [NUM_CH-1:0][ERR_W-1:0]       smp_err,
   input  logic                               abort_gap,
   input  logic                               tbl_wr_en,
   input  logic [CH_W-1:0]                    tbl_wr_ch,
   input  logic [CODE_W-1:0]                  tbl_wr_addr,
   input  logic [ET_W-1:0]                    tbl_wr_data,
   input  logic [ET_W-1:0]                    mu_lo,
   input  logic [ET_W-1:0]                    mu_hi,
   output logic                               frm_valid,
   output logic [FRM_W-1:0]                   frm_data
);
   if (CODE_W > 12) begin : g_bad_code
      $error("trig_tower_formatter: CODE_W too large");
   end
   if (NUM_TOW != 2) begin : g_bad_tow
      $error("trig_tower_formatter: frame format holds two towers");
   end

   // stage 1: table lookup
   logic [ET_W-1:0]                lut_q [NUM_CH];
   logic [NUM_CH-1:0][ERR_W-1:0]   err_s1;
   logic                           vld_s1;
   logic                           abort_s1;

   for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
      logic we;
      assign we = tbl_wr_en && (tbl_wr_ch == CH_W'(c));
      tpf_lut #(.ADDR_W(CODE_W), .DATA_W(ET_W)) u_lut (
         .clk     (clk),
         .wr_en   (we),
         .wr_addr (tbl_wr_addr),
         .wr_data (tbl_wr_data),
         .rd_addr (smp_code[c]),
         .rd_data (lut_q[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_s1   <= 1'b0;
         abort_s1 <= 1'b0;
         err_s1   <= '0;
      end else begin
         vld_s1   <= smp_valid;
         abort_s1 <= abort_gap;
         err_s1   <= smp_err;
      end
   end

   // stage 2: sum, window, truncation per tower
   logic [OUT_W-1:0]   et_t [NUM_TOW];
   logic [NUM_TOW-1:0] mu_t;
   logic               vld_s2;
   logic               abort_s2;

   for (genvar t = 0; t < int'(NUM_TOW); t++) begin : g_tow
      tpf_tower #(.ET_W(ET_W), .OUT_W(OUT_W), .ERR_W(ERR_W)) u_tow (
         .clk    (clk),
         .rst_n  (rst_n),
         .in_vld (vld_s1),
         .et_f   (lut_q[DEP_PER_TOW*t]),
         .et_b   (lut_q[DEP_PER_TOW*t+1]),
         .err_f  (err_s1[DEP_PER_TOW*t]),
         .err_b  (err_s1[DEP_PER_TOW*t+1]),
         .mu_lo  (mu_lo),
         .mu_hi  (mu_hi),
         .et_o   (et_t[t]),
         .mu_o   (mu_t[t])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_s2   <= 1'b0;
         abort_s2 <= 1'b0;
      end else begin
         vld_s2   <= vld_s1;
         abort_s2 <= abort_s1;
      end
   end

   // stage 3: protected frame
   tpf_frame_pack #(.OUT_W(OUT_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_vld  (vld_s2),
      .et_a    (et_t[0]),
      .mu_a    (mu_t[0]),
      .et_b    (et_t[1]),
      .mu_b    (mu_t[1]),
      .abort   (abort_s2),
      .frm_vld (frm_valid),
      .frm     (frm_data)
   );

   // R8: frame strobe trails the sample strobe by exactly three clocks
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid == $past(smp_valid, 3));
endmodule

// File: tb/trig_tower_formatter_tb_top.sv
module trig_tower_formatter_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic             smp_valid;
   logic [3:0][7:0]  smp_code;
   logic [3:0][1:0]  smp_err;
   logic             abort_gap;
   logic             tbl_wr_en;
   logic [1:0]       tbl_wr_ch;
   logic [7:0]       tbl_wr_addr;
   logic [15:0]      tbl_wr_data;
   logic [15:0]      mu_lo;
   logic [15:0]      mu_hi;
   logic             frm_valid;
   logic [23:0]      frm_data;

   trig_tower_formatter dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
      .smp_err(smp_err), .abort_gap(abort_gap), .tbl_wr_en(tbl_wr_en),
      .tbl_wr_ch(tbl_wr_ch), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
      .mu_lo(mu_lo), .mu_hi(mu_hi), .frm_valid(frm_valid), .frm_data(frm_data)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;
   int mdl [4][256];

   typedef struct { int due; logic [18:0] pay; } exp_t;
   exp_t q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic bit chkpos(input int p);
      return (p == 1) || (p == 2) || (p == 4) || (p == 8) || (p == 16);
   endfunction

   // R6 R7: expected frame from payload
   function automatic logic [23:0] mk_frame(input logic [18:0] pay);
      logic [23:0] f;
      int di;
      f = '0; di = 0;
      for (int p = 1; p <= 24; p++)
         if (!chkpos(p)) begin f[p-1] = pay[di]; di++; end
      for (int k = 0; k < 5; k++) begin
         logic x;
         x = 1'b0;
         for (int p = 1; p <= 24; p++)
            if (((p >> k) & 1) == 1 && p != (1 << k)) x = x ^ f[p-1];
         f[(1 << k) - 1] = x;
      end
      return f;
   endfunction

   function automatic logic [18:0] get_pay(input logic [23:0] f);
      logic [18:0] r;
      int di;
      r = '0; di = 0;
      for (int p = 1; p <= 24; p++)
         if (!chkpos(p)) begin r[di] = f[p-1]; di++; end
      return r;
   endfunction

   function automatic logic [8:0] tower(input int f, input int b, input bit bad);
      int s;
      logic [7:0] et;
      logic mu;
      s = f + b;
      if (bad) return {1'b0, 8'hFF};
      et = (s > 255) ? 8'hFF : s[7:0];
      mu = (s >= int'(mu_lo)) && (s <= int'(mu_hi));
      return {mu, et};
   endfunction

   task automatic check_out();
      if (q.size() > 0 && q[0].due == cyc) begin
         logic [18:0] ap;
         logic [18:0] ep;
         ep = q[0].pay;
         ap = get_pay(frm_data);
         void'(q.pop_front());
         chk("R8 frame valid", {31'd0, frm_valid}, 32'd1);
         chk("R1/R2/R3/R4 tower A ET", {24'd0, ap[7:0]}, {24'd0, ep[7:0]});
         chk("R5/R4 tower A muon", {31'd0, ap[8]}, {31'd0, ep[8]});
         chk("R1/R2/R3/R4 tower B ET", {24'd0, ap[16:9]}, {24'd0, ep[16:9]});
         chk("R5/R4 tower B muon", {31'd0, ap[17]}, {31'd0, ep[17]});
         chk("R10 abort flag", {31'd0, ap[18]}, {31'd0, ep[18]});
         chk("R6/R7 full frame", {8'd0, frm_data}, {8'd0, mk_frame(ep)});
      end else begin
         chk("R8 no frame", {31'd0, frm_valid}, 32'd0);
      end
   endtask

   // inputs are already driven; model the capture edge, then observe
   task automatic tick();
      if (smp_valid) begin
         exp_t e;
         logic [8:0] ta;
         logic [8:0] tb;
         ta = tower(mdl[0][smp_code[0]], mdl[1][smp_code[1]], |{smp_err[0], smp_err[1]});
         tb = tower(mdl[2][smp_code[2]], mdl[3][smp_code[3]], |{smp_err[2], smp_err[3]});
         e.due = cyc + 3;
         e.pay = {abort_gap, tb[8], tb[7:0], ta[8], ta[7:0]};
         q.push_back(e);
      end
      if (tbl_wr_en) mdl[tbl_wr_ch][tbl_wr_addr] = int'(tbl_wr_data);
      @(negedge clk);
      check_out();
   endtask

   task automatic idle();
      smp_valid = 0; tbl_wr_en = 0; smp_err = '0; abort_gap = 0;
   endtask

   task automatic sample(input int c0, input int c1, input int c2, input int c3,
                         input logic [7:0] errs, input bit ab);
      smp_valid = 1; tbl_wr_en = 0;
      smp_code[0] = 8'(c0); smp_code[1] = 8'(c1);
      smp_code[2] = 8'(c2); smp_code[3] = 8'(c3);
      smp_err = errs; abort_gap = ab;
      tick();
   endtask

   task automatic drain();
      idle();
      for (int i = 0; i < 4; i++) tick();
   endtask

   function automatic int tval(input int c, input int a);
      if (a == 255) return 65535;
      if (a < 128) return a + c;
      return (a * 131 + c * 7) & 16'hFFFF;
   endfunction

   initial begin
      #2000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL R8 watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 0; smp_code = '0; mu_lo = 16'd40; mu_hi = 16'd100;
      tbl_wr_ch = 0; tbl_wr_addr = 0; tbl_wr_data = 0;
      idle();
      repeat (3) @(negedge clk);
      chk("R9 reset valid", {31'd0, frm_valid}, 32'd0);
      chk("R9 reset frame", {8'd0, frm_data}, 32'd0);
      rst_n = 1;
      // load all tables (R1)
      for (int c = 0; c < 4; c++)
         for (int a = 0; a < 256; a++) begin
            tbl_wr_en = 1; tbl_wr_ch = 2'(c); tbl_wr_addr = 8'(a);
            tbl_wr_data = 16'(tval(c, a));
            tick();
         end
      idle();
      // R5 window edges: A sums 40,100 / 39,101 ; B sums inside and outside
      sample(20, 19, 10, 10, 8'h00, 0);
      sample(50, 49, 30, 29, 8'h00, 1);
      sample(20, 18, 90, 9, 8'h00, 0);
      sample(51, 49, 5, 0, 8'h00, 1);
      // R3 sums 255 and 256
      sample(127, 127, 126, 125, 8'h00, 0);
      // R4 error inside the window, each channel position
      sample(30, 30, 30, 30, 8'h01, 0);
      sample(30, 30, 30, 30, 8'h08, 0);
      sample(30, 30, 30, 30, 8'h30, 0);
      sample(30, 30, 30, 30, 8'h80, 1);
      drain();
      // R5 17-bit sum must not alias into a full 16-bit window
      mu_lo = 16'd0; mu_hi = 16'hFFFF;
      sample(255, 255, 255, 0, 8'h00, 0);
      sample(0, 0, 200, 201, 8'h00, 0);
      drain();
      mu_lo = 16'd40; mu_hi = 16'd100;
      // R1 same-edge write reads old, next sample sees new
      smp_valid = 1; smp_err = '0; abort_gap = 0;
      smp_code[0] = 8'd20; smp_code[1] = 8'd20; smp_code[2] = 8'd1; smp_code[3] = 8'd1;
      tbl_wr_en = 1; tbl_wr_ch = 2'd0; tbl_wr_addr = 8'd20; tbl_wr_data = 16'd200;
      tick();
      tbl_wr_en = 0;
      tick();
      drain();
      // R8 back-to-back random traffic with sparse writes
      for (int n = 0; n < 600; n++) begin
         smp_valid = ($urandom_range(0, 3) != 0);
         for (int c = 0; c < 4; c++) begin
            smp_code[c] = 8'($urandom_range(0, 255));
            smp_err[c] = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
         end
         abort_gap = 1'($urandom_range(0, 1));
         tbl_wr_en = ($urandom_range(0, 7) == 0);
         tbl_wr_ch = 2'($urandom_range(0, 3));
         tbl_wr_addr = 8'($urandom_range(0, 255));
         tbl_wr_data = 16'($urandom_range(0, 300));
         tick();
      end
      drain();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule